// File: doc/BRIEF.md
# Nanosecond Time-of-Day Counter with Capture, Load and Step Actions

The block keeps a running time of day as a 48-bit seconds count and a 30-bit nanoseconds count. On every clock tick the nanoseconds advance by a fixed nominal increment. A small signed trim, supplied each cycle by a separate frequency-correction block, is added to that increment. When the nanoseconds pass 999,999,999 they wrap and carry into the seconds.

Software reaches the counter through a register-style port. A pair of shadow registers holds seconds (an upper 16-bit word and a lower 32-bit word) and nanoseconds. Software writes a one-shot action code. The code sits in an action register for one cycle, executes on the next clock edge and then clears itself.

There are three actions. SAVE copies the live time into the shadow registers. LOAD makes the shadow time the new live time. DELTA steps the live time by the shadow nanoseconds, read as a signed value. Large corrections are not done with DELTA: software does them by a SAVE followed by a LOAD.

The action register is a four-state machine: ACT_IDLE, ACT_SAVE, ACT_LOAD and ACT_DELTA. Its transitions are as follows.

- ACT_IDLE moves to the state named by the written code on an action write.
- ACT_IDLE stays in ACT_IDLE when no action is written.
- ACT_SAVE, ACT_LOAD and ACT_DELTA each return to ACT_IDLE after one cycle, whatever is on the inputs.

Top module: `tod_clock_core`

## Requirements
- R1: A synchronous active-low reset clears the live seconds, live nanoseconds, both shadow registers and the action code (to IDLE, value 0).
- R2: In a cycle with no LOAD executing, the live nanoseconds advance by INC_NS plus the two's-complement trim input. On reaching one second (1,000,000,000) they wrap, and the seconds (48 bits) increase by one.
- R3: The 2-bit action codes are IDLE=0, SAVE=1, LOAD=2 and DELTA=3. A code written with `act_wr_i` is shown on `act_code_o` during the next cycle and executes at the end of that cycle. `act_code_o` then returns to 0.
- R4: An action write that arrives while a non-IDLE code is pending is ignored.
- R5: SAVE copies the live seconds and nanoseconds into the shadow registers, both from the same cycle: the cycle in which SAVE is pending. The copy appears on the shadow outputs one cycle later.
- R6: A software shadow write (`shd_wr_i`) updates all three shadow fields. If it falls in the same cycle as an executing SAVE, the SAVE wins.
- R7: LOAD replaces the live time with the shadow seconds and nanoseconds, with no increment added in that cycle.
- R8: On LOAD, shadow nanoseconds in the range 0x3FFFFFF0 to 0x3FFFFFFF mean a negative offset. The live time becomes shadow seconds minus one, with nanoseconds (value & 0xF) + 999,999,984.
- R9: On LOAD, shadow nanoseconds from 1,000,000,000 up to 0x3FFFFFEF carry: the live time becomes seconds plus one, with nanoseconds minus 1,000,000,000.
- R10: DELTA adds the shadow nanoseconds, read as a signed 30-bit value, to the live time together with that cycle's tick. A result below zero borrows from the seconds, and a result past one second carries into them. Shadow seconds are ignored.
- R11: A DELTA whose signed step has magnitude of 500,000,000 or more is not applied; the time just ticks.
- R12: The live nanoseconds output is always below 1,000,000,000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trim_i | input | 4 | Signed per-tick correction from the frequency trim block |
| act_wr_i | input | 1 | Action write strobe |
| act_code_i | input | 2 | Action code to write |
| shd_wr_i | input | 1 | Shadow register write strobe |
| shd_sec_hi_i | input | 16 | Shadow seconds upper word to write |
| shd_sec_lo_i | input | 32 | Shadow seconds lower word to write |
| shd_ns_i | input | 30 | Shadow nanoseconds to write |
| act_code_o | output | 2 | Pending action code |
| shd_sec_hi_o | output | 16 | Shadow seconds upper word |
| shd_sec_lo_o | output | 32 | Shadow seconds lower word |
| shd_ns_o | output | 30 | Shadow nanoseconds |
| tod_sec_o | output | 48 | Live seconds |
| tod_ns_o | output | 30 | Live nanoseconds |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a DELTA step and the per-tick second rollover. The bench loads a time a few nanoseconds before or after a second boundary and then issues DELTA steps that cross it in both directions. The result is judged on whether the borrow or carry into the seconds is taken exactly once.

The second pair is a SAVE capture and a software shadow write in the same edge. Here the judgement is whether the shadow holds the captured live time rather than the written words. Random traffic, including action writes during pending actions, is compared cycle by cycle with a bench model.

// File: rtl/tod_pkg.sv
package tod_pkg;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_SAVE  = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_DELTA = 2'd3
    } tod_act_e;

endpackage

// File: rtl/tod_ns_norm.sv
module tod_ns_norm #(
    parameter int NS_W       = 30,
    parameter int SUM_W      = 32,
    parameter int NS_PER_SEC = 1_000_000_000
) (
    input  logic signed [SUM_W-1:0] sum_i,
    output logic [NS_W-1:0]         ns_o,
    output logic                    carry_o,
    output logic                    borrow_o
);
    localparam logic signed [SUM_W-1:0] ONE_SEC = SUM_W'(NS_PER_SEC);

    logic signed [SUM_W-1:0] fixed;

    always_comb begin
        carry_o  = 1'b0;
        borrow_o = 1'b0;
        fixed    = sum_i;
        if (sum_i < 0) begin
            borrow_o = 1'b1;
            fixed    = sum_i + ONE_SEC;
        end else if (sum_i >= ONE_SEC) begin
            carry_o = 1'b1;
            fixed   = sum_i - ONE_SEC;
        end
        ns_o = fixed[NS_W-1:0];
    end

endmodule

// File: rtl/tod_action_fsm.sv
module tod_action_fsm
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       act_wr_i,
    input  logic [1:0] act_code_i,
    output logic [1:0] act_code_o,
    output logic       exec_save_o,
    output logic       exec_load_o,
    output logic       exec_delta_o
);
    tod_act_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACT_IDLE:  if (act_wr_i) state_d = tod_act_e'(act_code_i);
            ACT_SAVE:  state_d = ACT_IDLE;
            ACT_LOAD:  state_d = ACT_IDLE;
            ACT_DELTA: state_d = ACT_IDLE;
            default:   state_d = ACT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        exec_save_o  = 1'b0;
        exec_load_o  = 1'b0;
        exec_delta_o = 1'b0;
        act_code_o   = state_q;
        unique case (state_q)
            ACT_IDLE:  ;
            ACT_SAVE:  exec_save_o  = 1'b1;
            ACT_LOAD:  exec_load_o  = 1'b1;
            ACT_DELTA: exec_delta_o = 1'b1;
            default:   ;
        endcase
    end

    // R3: a pending action clears itself after one cycle
    a_r3_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ACT_IDLE) |=> (state_q == ACT_IDLE));

    // R3: a write from idle becomes the pending code
    a_r3_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACT_IDLE && act_wr_i) |=> (act_code_o == $past(act_code_i)));

endmodule

// File: rtl/tod_shadow.sv
module tod_shadow #(
    parameter int SEC_W = 48,
    parameter int NS_W  = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic [SEC_W-1:0] live_sec_i,
    input  logic [NS_W-1:0]  live_ns_i,
    input  logic             sw_wr_i,
    input  logic [SEC_W-1:0] sw_sec_i,
    input  logic [NS_W-1:0]  sw_ns_i,
    output logic [SEC_W-1:0] shd_sec_o,
    output logic [NS_W-1:0]  shd_ns_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_sec_o <= '0;
            shd_ns_o  <= '0;
        end else if (capture_i) begin
            shd_sec_o <= live_sec_i;
            shd_ns_o  <= live_ns_i;
        end else if (sw_wr_i) begin
            shd_sec_o <= sw_sec_i;
            shd_ns_o  <= sw_ns_i;
        end
    end

    // R5: both words come from the same captured instant
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> (shd_sec_o == $past(live_sec_i)) && (shd_ns_o == $past(live_ns_i)));

    // R6: software write lands when no capture competes
    a_r6_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_i && !capture_i) |=> (shd_sec_o == $past(sw_sec_i)) && (shd_ns_o == $past(sw_ns_i)));

endmodule

// File: rtl/tod_clock_core.sv
module tod_clock_core #(
    parameter int SEC_W      = 48,
    parameter int SEC_LO_W   = 32,
    parameter int NS_W       = 30,
    parameter int TRIM_W     = 4,
    parameter int INC_NS     = 8,
    parameter int NS_PER_SEC = 1_000_000_000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [TRIM_W-1:0]         trim_i,
    input  logic                      act_wr_i,
    input  logic [1:0]                act_code_i,
    input  logic                      shd_wr_i,
    input  logic [SEC_W-SEC_LO_W-1:0] shd_sec_hi_i,
    input  logic [SEC_LO_W-1:0]       shd_sec_lo_i,
    input  logic [NS_W-1:0]           shd_ns_i,
    output logic [1:0]                act_code_o,
    output logic [SEC_W-SEC_LO_W-1:0] shd_sec_hi_o,
    output logic [SEC_LO_W-1:0]       shd_sec_lo_o,
    output logic [NS_W-1:0]           shd_ns_o,
    output logic [SEC_W-1:0]          tod_sec_o,
    output logic [NS_W-1:0]           tod_ns_o
);
    localparam int SUM_W    = NS_W + 2;
    localparam int NEG_BITS = 4;
    localparam logic signed [SUM_W-1:0] INC_S   = SUM_W'(INC_NS);
    localparam logic signed [SUM_W-1:0] HALF_NS = SUM_W'(NS_PER_SEC / 2);

    logic             exec_save, exec_load, exec_delta;
    logic [SEC_W-1:0] sec_q;
    logic [NS_W-1:0]  ns_q;
    logic [SEC_W-1:0] shd_sec;
    logic [NS_W-1:0]  shd_ns;

    tod_action_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .act_wr_i     (act_wr_i),
        .act_code_i   (act_code_i),
        .act_code_o   (act_code_o),
        .exec_save_o  (exec_save),
        .exec_load_o  (exec_load),
        .exec_delta_o (exec_delta)
    );

    tod_shadow #(.SEC_W(SEC_W), .NS_W(NS_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_i  (exec_save),
        .live_sec_i (sec_q),
        .live_ns_i  (ns_q),
        .sw_wr_i    (shd_wr_i),
        .sw_sec_i   ({shd_sec_hi_i, shd_sec_lo_i}),
        .sw_ns_i    (shd_ns_i),
        .shd_sec_o  (shd_sec),
        .shd_ns_o   (shd_ns)
    );

    // Tick path: live ns + increment + trim + accepted step
    logic signed [SUM_W-1:0] trim_s, delta_s, step_s, tick_sum;
    logic                    delta_ok;
    logic [NS_W-1:0]         tick_ns;
    logic                    tick_carry, tick_borrow;

    always_comb begin
        trim_s   = SUM_W'($signed(trim_i));
        delta_s  = SUM_W'($signed(shd_ns));
        delta_ok = (delta_s > -HALF_NS) && (delta_s < HALF_NS);
        step_s   = (exec_delta && delta_ok) ? delta_s : '0;
        tick_sum = $signed(SUM_W'(ns_q)) + INC_S + trim_s + step_s;
    end

    tod_ns_norm #(.NS_W(NS_W), .SUM_W(SUM_W), .NS_PER_SEC(NS_PER_SEC)) u_tick_norm (
        .sum_i    (tick_sum),
        .ns_o     (tick_ns),
        .carry_o  (tick_carry),
        .borrow_o (tick_borrow)
    );

    // Load path: decode the negative-offset window, then normalize
    logic                    neg_code;
    logic signed [SUM_W-1:0] load_sum;
    logic [NS_W-1:0]         load_ns;
    logic                    load_carry, load_borrow;

    always_comb begin
        neg_code = &shd_ns[NS_W-1:NEG_BITS];
        if (neg_code) load_sum = SUM_W'($signed({1'b1, shd_ns[NEG_BITS-1:0]}));
        else          load_sum = $signed(SUM_W'(shd_ns));
    end

    tod_ns_norm #(.NS_W(NS_W), .SUM_W(SUM_W), .NS_PER_SEC(NS_PER_SEC)) u_load_norm (
        .sum_i    (load_sum),
        .ns_o     (load_ns),
        .carry_o  (load_carry),
        .borrow_o (load_borrow)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            ns_q  <= '0;
        end else if (exec_load) begin
            sec_q <= shd_sec + SEC_W'(load_carry) - SEC_W'(load_borrow);
            ns_q  <= load_ns;
        end else begin
            sec_q <= sec_q + SEC_W'(tick_carry) - SEC_W'(tick_borrow);
            ns_q  <= tick_ns;
        end
    end

    assign tod_sec_o    = sec_q;
    assign tod_ns_o     = ns_q;
    assign shd_sec_hi_o = shd_sec[SEC_W-1:SEC_LO_W];
    assign shd_sec_lo_o = shd_sec[SEC_LO_W-1:0];
    assign shd_ns_o     = shd_ns;

    // R12: live nanoseconds stay inside one second
    a_r12_ns_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ns_q) < NS_PER_SEC);

    // R2: a plain tick without wrap leaves seconds alone
    a_r2_plain_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_load && !exec_delta && (int'(ns_q) + INC_NS + int'($signed(trim_i)) < NS_PER_SEC))
        |=> (int'(ns_q) == $past(int'(ns_q) + INC_NS + int'($signed(trim_i)))) && $stable(sec_q));

    // R7: an in-range load lands unchanged
    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_load && int'(shd_ns) < NS_PER_SEC)
        |=> (ns_q == $past(shd_ns)) && (sec_q == $past(shd_sec)));

    // R11: an oversized step behaves as a plain tick
    a_r11_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_delta && !delta_ok && (int'(ns_q) + INC_NS + int'($signed(trim_i)) < NS_PER_SEC))
        |=> $stable(sec_q));

endmodule

// File: tb/tod_clock_core_tb.sv
`timescale 1ns/1ps
module tod_clock_core_tb_top;
    localparam int  INC     = 8;
    localparam longint ONE  = 1_000_000_000;
    localparam longint HALF = 500_000_000;
    localparam longint MASK = 64'h0000_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  trim_i = '0;
    logic        act_wr_i = 1'b0;
    logic [1:0]  act_code_i = '0;
    logic        shd_wr_i = 1'b0;
    logic [15:0] shd_sec_hi_i = '0;
    logic [31:0] shd_sec_lo_i = '0;
    logic [29:0] shd_ns_i = '0;
    logic [1:0]  act_code_o;
    logic [15:0] shd_sec_hi_o;
    logic [31:0] shd_sec_lo_o;
    logic [29:0] shd_ns_o;
    logic [47:0] tod_sec_o;
    logic [29:0] tod_ns_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tod_clock_core dut_i (
        .clk(clk), .rst_n(rst_n), .trim_i(trim_i),
        .act_wr_i(act_wr_i), .act_code_i(act_code_i),
        .shd_wr_i(shd_wr_i), .shd_sec_hi_i(shd_sec_hi_i),
        .shd_sec_lo_i(shd_sec_lo_i), .shd_ns_i(shd_ns_i),
        .act_code_o(act_code_o), .shd_sec_hi_o(shd_sec_hi_o),
        .shd_sec_lo_o(shd_sec_lo_o), .shd_ns_o(shd_ns_o),
        .tod_sec_o(tod_sec_o), .tod_ns_o(tod_ns_o)
    );

    // Reference model state
    longint m_sec, m_ns, m_shs, m_shn;
    int     m_act;
    string  m_tag = "R1";

    function automatic longint norm_ns(input longint v, inout longint sec);
        if (v < 0) begin
            sec = (sec - 1) & MASK;
            return v + ONE;
        end else if (v >= ONE) begin
            sec = (sec + 1) & MASK;
            return v - ONE;
        end
        return v;
    endfunction

    function automatic longint sext30(input longint v);
        return (v >= 64'h2000_0000) ? v - 64'h4000_0000 : v;
    endfunction

    always @(posedge clk) begin
        longint o_sec, o_ns, o_shs, o_shn, v, d, s;
        int o_act;
        if (!rst_n) begin
            m_sec = 0; m_ns = 0; m_shs = 0; m_shn = 0; m_act = 0; m_tag = "R1";
        end else begin
            o_sec = m_sec; o_ns = m_ns; o_shs = m_shs; o_shn = m_shn; o_act = m_act;
            m_tag = "R2";
            if (o_act == 2) begin
                if (o_shn >= 64'h3FFF_FFF0) begin v = (o_shn & 15) - 16; m_tag = "R8"; end
                else begin v = o_shn; m_tag = (o_shn >= ONE) ? "R9" : "R7"; end
                s = o_shs;
                m_ns = norm_ns(v, s);
                m_sec = s;
            end else begin
                d = 0;
                if (o_act == 3) begin
                    d = sext30(o_shn);
                    if (d > -HALF && d < HALF) m_tag = "R10";
                    else begin d = 0; m_tag = "R11"; end
                end
                v = o_ns + INC + (trim_i[3] ? longint'(trim_i) - 16 : longint'(trim_i)) + d;
                s = o_sec;
                m_ns = norm_ns(v, s);
                m_sec = s;
            end
            if (o_act == 1) begin
                m_shs = o_sec; m_shn = o_ns; m_tag = (shd_wr_i ? "R6" : "R5");
            end else if (shd_wr_i) begin
                m_shs = {shd_sec_hi_i, shd_sec_lo_i}; m_shn = shd_ns_i;
            end
            if (o_act != 0) begin
                m_act = 0;
                if (act_wr_i) m_tag = "R4";
            end else begin
                m_act = act_wr_i ? int'(act_code_i) : 0;
            end
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Sample at the falling edge, compare against the model
    task automatic step();
        @(negedge clk);
        chk({m_tag, " time sec"}, longint'(tod_sec_o), m_sec);
        chk({m_tag, " time ns"}, longint'(tod_ns_o), m_ns);
        chk("R3 act code", longint'(act_code_o), longint'(m_act));
        chk({m_tag, " shadow sec"}, longint'({shd_sec_hi_o, shd_sec_lo_o}), m_shs);
        chk({m_tag, " shadow ns"}, longint'(shd_ns_o), m_shn);
        chk("R12 ns range", longint'(tod_ns_o < 30'd1_000_000_000), 1);
    endtask

    task automatic wr_shadow(input longint sec, input longint ns);
        shd_wr_i = 1'b1;
        shd_sec_hi_i = sec[47:32];
        shd_sec_lo_i = sec[31:0];
        shd_ns_i = ns[29:0];
        step();
        shd_wr_i = 1'b0;
    endtask

    task automatic do_act(input int code);
        act_wr_i = 1'b1;
        act_code_i = code[1:0];
        step();
        act_wr_i = 1'b0;
        step();
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: state after reset
        chk("R1 reset sec", longint'(tod_sec_o), 0);
        chk("R1 reset ns", longint'(tod_ns_o), 0);
        chk("R1 reset act", longint'(act_code_o), 0);
        chk("R1 reset shadow", longint'(shd_ns_o), 0);
        rst_n = 1'b1;
        step(); step();
        chk("R2 first ticks", longint'(tod_ns_o), 2 * INC);

        // R7 then R2 wrap across a second boundary
        wr_shadow(5, 999_999_990);
        do_act(2);
        chk("R7 load ns", longint'(tod_ns_o), 999_999_990);
        chk("R7 load sec", longint'(tod_sec_o), 5);
        step(); step();
        chk("R2 wrap sec", longint'(tod_sec_o), 6);
        chk("R2 wrap ns", longint'(tod_ns_o), 6);

        // R8 negative-offset encoding
        wr_shadow(100, 64'h3FFF_FFF3);
        do_act(2);
        chk("R8 neg sec", longint'(tod_sec_o), 99);
        chk("R8 neg ns", longint'(tod_ns_o), 999_999_987);

        // R9 over-range load carries
        wr_shadow(7, 1_000_000_004);
        do_act(2);
        chk("R9 carry sec", longint'(tod_sec_o), 8);
        chk("R9 carry ns", longint'(tod_ns_o), 4);

        // R10 negative step borrows (shadow seconds ignored)
        wr_shadow(3, 10);
        do_act(2);
        wr_shadow(64'h1234, (64'h4000_0000 - 100));
        do_act(3);
        chk("R10 borrow sec", longint'(tod_sec_o), 2);
        chk("R10 borrow ns", longint'(tod_ns_o), 10 + 3 * INC - 100 + ONE);

        // R10 positive step carries together with the tick
        wr_shadow(9, 999_999_000);
        do_act(2);
        wr_shadow(0, 2000);
        do_act(3);
        chk("R10 carry sec", longint'(tod_sec_o), 10);
        chk("R10 carry ns", longint'(tod_ns_o), 999_999_000 + 3 * INC + 2000 - ONE);

        // R11 oversized steps both ways
        wr_shadow(0, 500_000_000);
        do_act(3);
        chk("R11 +half rejected", longint'(tod_sec_o), 10);
        wr_shadow(0, 64'h4000_0000 - 500_000_000);
        do_act(3);
        chk("R11 -half rejected", longint'(tod_sec_o), 10);

        // R6 capture and software write in the same edge
        act_wr_i = 1'b1; act_code_i = 2'd1;
        step();
        act_wr_i = 1'b0;
        shd_wr_i = 1'b1; shd_sec_hi_i = 16'hAAAA; shd_sec_lo_i = 32'h5555_5555; shd_ns_i = 30'd77;
        step();
        shd_wr_i = 1'b0;
        chk("R6 save wins sec", longint'({shd_sec_hi_o, shd_sec_lo_o}), 10);
        chk("R5 saved ns", longint'(shd_ns_o) == longint'(tod_ns_o) - INC ? 1 : 0, 1);

        // R4 write while pending is ignored
        act_wr_i = 1'b1; act_code_i = 2'd2;
        step();
        act_code_i = 2'd1;
        step();
        act_wr_i = 1'b0;
        chk("R4 ignored write", longint'(act_code_o), 0);

        // Random traffic, checked against the model every cycle
        for (int i = 0; i < 4000; i++) begin
            int r;
            trim_i = 4'($urandom_range(0, 15));
            act_wr_i = ($urandom_range(0, 3) == 0);
            act_code_i = 2'($urandom_range(0, 3));
            shd_wr_i = ($urandom_range(0, 4) == 0);
            shd_sec_hi_i = 16'($urandom);
            shd_sec_lo_i = $urandom;
            r = $urandom_range(0, 5);
            case (r)
                0: shd_ns_i = 30'($urandom_range(0, 999_999_999));
                1: shd_ns_i = 30'($urandom_range(999_999_900, 999_999_999));
                2: shd_ns_i = 30'(32'h4000_0000 - $urandom_range(1, 2000));
                3: shd_ns_i = 30'(32'h3FFF_FFF0 + $urandom_range(0, 15));
                4: shd_ns_i = 30'($urandom_range(1_000_000_000, 32'h3FFF_FFEF));
                default: shd_ns_i = 30'($urandom);
            endcase
            step();
        end
        act_wr_i = 1'b0;
        shd_wr_i = 1'b0;
        step();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule